// File: doc/BRIEF.md
# Subtree Pruning Threshold and Decision Unit

This block serves a depth-first, single-pass soft-output tree detector. When the search stands on a parent node and is about to step down to the children on level `i`, the unit forms the pruning threshold for those children. It chooses a set of counter-hypothesis metrics and takes their maximum. It then compares one candidate child's partial Euclidean distance against that threshold and raises a prune flag. Only the parent's partial label decides the threshold, so the same threshold serves every child. The enumerator can therefore walk the children in ascending-distance order and stop at the first one that is pruned.

Levels run from `NLVL` just below the root down to 1 at the leaves. The metric set covers two groups. The first is every metric on levels at or below the child level. The second is, on the levels above it, only those metrics whose parent label bit disagrees with the matching bit of the current best label. The best metric never enters the set, because it never exceeds a counter metric. The unit is purely combinational. It is fed from registers in the surrounding search datapath, and its outputs are valid in the same cycle as the query.

Top module: `ptg_threshold`

## Requirements
- R1: For a level j above the child level (j > `child_lvl`), the metric of bit (j,b) enters the set exactly when label bit index (j-1)*NBIT+b of `part_label` differs from the same bit of `best_label`. Metric (j,b) sits in `cmetric` bits [((j-1)*NBIT+b)*MW +: MW].
- R2: Every metric on levels 1..`child_lvl` enters the set, whatever the label bits.
- R3: `thresh` equals the largest metric in the set.
- R4: `prune` is 1 exactly when `cand_ped` is strictly greater than `thresh`. An equal distance is kept.
- R5: The all-ones metric code stands for infinity. When such a metric is in the set, `thresh` is all ones and `prune` is 0 for every distance.
- R6: Label bits at levels 1..`child_lvl`, in either label, have no effect on `thresh` or `prune`.
- R7: With `child_lvl` = NLVL (children of the root), `thresh` is the maximum of all metrics, and neither label has any effect.
- R8: `thresh` and `prune` follow the inputs within the same cycle, with no register between them.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| child_lvl | input | $clog2(NLVL+1) | Level of the children being expanded, 1..NLVL |
| part_label | input | NLVL*NBIT | Parent partial label, bit (j-1)*NBIT+b for level j, bit b |
| best_label | input | NLVL*NBIT | Label of the current best leaf, same layout |
| cmetric | input | NLVL*NBIT*MW | Counter-hypothesis metrics, one MW-bit field per label bit |
| cand_ped | input | MW | Partial Euclidean distance of the candidate child |
| thresh | output | MW | Pruning threshold for the children of the parent |
| prune | output | 1 | 1 when the candidate child and its subtree are to be skipped |

## Verification
Random queries draw a level, both labels and all sixteen metrics. The candidate distance is placed exactly on the expected threshold, one above it, one below it, or at random, which separates a strict comparison from a non-strict one. Directed cases change a single disagreeing bit above the child level, which shows whether the label comparison is applied per bit and per level, and they place an infinite metric inside and outside the set. A pairwise test flips only the label bits at or below the child level and requires identical outputs, which tells the unconditional region apart from the conditional one. Root-child queries with random labels confirm that the labels are ignored there.

// File: rtl/ptg_pkg.sv
package ptg_pkg;
    localparam int unsigned PTG_NLVL = 4;
    localparam int unsigned PTG_NBIT = 4;
    localparam int unsigned PTG_MW   = 16;
endpackage

// File: rtl/ptg_select_mask.sv
module ptg_select_mask #(
    parameter int NLVL = 4,
    parameter int NBIT = 4,
    parameter int LW   = 3,
    localparam int NB  = NLVL * NBIT
) (
    input  logic [LW-1:0] child_lvl,
    input  logic [NB-1:0] part_label,
    input  logic [NB-1:0] best_label,
    output logic [NB-1:0] incl
);
    // A metric is eligible if its level is at or below the child level,
    // or if its parent label bit disagrees with the best label.
    for (genvar j = 0; j < NLVL; j++) begin : g_lvl
        localparam logic [LW-1:0] LVL_NUM = LW'(j + 1);
        logic low_side;
        assign low_side = (LVL_NUM <= child_lvl);
        for (genvar b = 0; b < NBIT; b++) begin : g_bit
            localparam int IDX = j * NBIT + b;
            assign incl[IDX] = low_side || (part_label[IDX] != best_label[IDX]);
        end
    end
endmodule

// File: rtl/ptg_max_tree.sv
module ptg_max_tree #(
    parameter int N  = 16,
    parameter int MW = 16,
    localparam int P = 1 << $clog2(N)
) (
    input  logic [N*MW-1:0] vals,
    input  logic [N-1:0]    en,
    output logic [MW-1:0]   mx
);
    // Heap-indexed balanced reduction: node 1 is the root, leaves at P..2P-1.
    logic [MW-1:0] node [1:2*P-1];

    for (genvar k = 0; k < P; k++) begin : g_leaf
        if (k < N) begin : g_real
            assign node[P+k] = en[k] ? vals[k*MW +: MW] : '0;
        end else begin : g_pad
            assign node[P+k] = '0;
        end
    end

    for (genvar k = 1; k < P; k++) begin : g_node
        assign node[k] = (node[2*k] >= node[2*k+1]) ? node[2*k] : node[2*k+1];
    end

    assign mx = node[1];
endmodule

// File: rtl/ptg_threshold.sv
module ptg_threshold
    import ptg_pkg::*;
#(
    parameter int NLVL = PTG_NLVL,
    parameter int NBIT = PTG_NBIT,
    parameter int MW   = PTG_MW,
    localparam int LW  = $clog2(NLVL + 1),
    localparam int NB  = NLVL * NBIT
) (
    input  logic [LW-1:0]    child_lvl,
    input  logic [NB-1:0]    part_label,
    input  logic [NB-1:0]    best_label,
    input  logic [NB*MW-1:0] cmetric,
    input  logic [MW-1:0]    cand_ped,
    output logic [MW-1:0]    thresh,
    output logic             prune
);
    logic [NB-1:0] incl;

    ptg_select_mask #(.NLVL(NLVL), .NBIT(NBIT), .LW(LW)) u_mask (
        .child_lvl  (child_lvl),
        .part_label (part_label),
        .best_label (best_label),
        .incl       (incl)
    );

    ptg_max_tree #(.N(NB), .MW(MW)) u_max (
        .vals (cmetric),
        .en   (incl),
        .mx   (thresh)
    );

    // Strict comparison: a distance equal to the threshold is still explored.
    assign prune = (cand_ped > thresh);
endmodule

// File: rtl/ptg_checker.sv
module ptg_checker #(
    parameter int NLVL = 4,
    parameter int NBIT = 4,
    parameter int MW   = 16,
    localparam int LW  = $clog2(NLVL + 1),
    localparam int NB  = NLVL * NBIT
) (
    input logic [LW-1:0]    child_lvl,
    input logic [NB-1:0]    part_label,
    input logic [NB-1:0]    best_label,
    input logic [NB*MW-1:0] cmetric,
    input logic [MW-1:0]    cand_ped,
    input logic [MW-1:0]    thresh,
    input logic             prune
);
    logic lvl_ok, over_seen, low_over, hit, inf_in;

    always_comb begin
        over_seen = 1'b0;
        low_over  = 1'b0;
        hit       = 1'b0;
        inf_in    = 1'b0;
        lvl_ok    = (child_lvl >= LW'(1)) && (child_lvl <= LW'(NLVL));
        for (int k = 0; k < NB; k++) begin
            logic is_low, inc;
            logic [MW-1:0] m;
            is_low = (LW'(k / NBIT + 1) <= child_lvl);
            inc    = is_low || (part_label[k] ^ best_label[k]);
            m      = cmetric[k*MW +: MW];
            if (inc && m > thresh) over_seen = 1'b1;
            if (is_low && m > thresh) low_over = 1'b1;
            if (inc && m == thresh) hit = 1'b1;
            if (inc && m == '1) inf_in = 1'b1;
        end
    end

    always_comb begin
        if (lvl_ok) begin
            // R3
            thresh_bound_chk: assert (!over_seen) else $error("threshold below an eligible metric");
            // R3
            thresh_member_chk: assert (hit) else $error("threshold is not an eligible metric");
            // R2
            low_level_chk: assert (!low_over) else $error("low-level metric exceeds threshold");
            // R5
            inf_open_chk: assert (!(inf_in && (thresh != '1 || prune))) else $error("infinite metric did not open the threshold");
            // R4
            equal_keep_chk: assert (!(prune && cand_ped == thresh)) else $error("pruned at equal distance");
        end
    end
endmodule

bind ptg_threshold ptg_checker #(.NLVL(NLVL), .NBIT(NBIT), .MW(MW)) u_chk (
    .child_lvl  (child_lvl),
    .part_label (part_label),
    .best_label (best_label),
    .cmetric    (cmetric),
    .cand_ped   (cand_ped),
    .thresh     (thresh),
    .prune      (prune)
);

// File: tb/ptg_threshold_bench.sv
`timescale 1ns/1ps
module ptg_threshold_bench;
    localparam int NLVL = 4;
    localparam int NBIT = 4;
    localparam int MW   = 16;
    localparam int LW   = $clog2(NLVL + 1);
    localparam int NB   = NLVL * NBIT;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic [LW-1:0]    child_lvl  = '0;
    logic [NB-1:0]    part_label = '0;
    logic [NB-1:0]    best_label = '0;
    logic [NB*MW-1:0] cmetric    = '0;
    logic [MW-1:0]    cand_ped   = '0;
    logic [MW-1:0]    thresh;
    logic             prune;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    ptg_threshold u_ptg_threshold (
        .child_lvl(child_lvl), .part_label(part_label), .best_label(best_label),
        .cmetric(cmetric), .cand_ped(cand_ped), .thresh(thresh), .prune(prune)
    );

    function automatic logic [MW-1:0] exp_thr(input int lvl, input logic [NB-1:0] p,
                                              input logic [NB-1:0] b, input logic [NB*MW-1:0] m);
        logic [MW-1:0] r = '0;
        for (int j = 1; j <= NLVL; j++) begin
            for (int q = 0; q < NBIT; q++) begin
                int k = (j - 1) * NBIT + q;
                if ((j <= lvl) || (p[k] != b[k]))
                    if (m[k*MW +: MW] > r) r = m[k*MW +: MW];
            end
        end
        return r;
    endfunction

    task automatic chk(input string tag, input logic [MW-1:0] act, input logic [MW-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Apply a query just after a rising edge and check before the next one (R8).
    task automatic run(input string tag);
        logic [MW-1:0] e;
        @(posedge clk);
        #0.5;
        e = exp_thr(int'(child_lvl), part_label, best_label, cmetric);
        #1;
        chk({tag, " thresh"}, thresh, e);
        chk({tag, " prune R4"}, {{(MW-1){1'b0}}, prune}, {{(MW-1){1'b0}}, (cand_ped > e)});
    endtask

    task automatic rand_query(input int lvl);
        child_lvl  = LW'(lvl);
        part_label = NB'($urandom);
        best_label = NB'($urandom);
        for (int k = 0; k < NB; k++)
            cmetric[k*MW +: MW] = ($urandom % 64 == 0) ? '1 : MW'($urandom % 65535);
    endtask

    task automatic pick_ped();
        logic [MW-1:0] e;
        e = exp_thr(int'(child_lvl), part_label, best_label, cmetric);
        case ($urandom % 4)
            0: cand_ped = e;
            1: cand_ped = e + 1'b1;
            2: cand_ped = e - 1'b1;
            default: cand_ped = MW'($urandom);
        endcase
    endtask

    initial begin
        void'($urandom(32'd20241));
        // Zeroed inputs: level 0 is outside the query range, all metrics zero.
        #1;
        chk("R3 zero thresh", thresh, '0);
        chk("R4 zero prune", {{(MW-1){1'b0}}, prune}, '0);

        // R1: a single disagreeing bit above the child level carries a large metric.
        child_lvl = LW'(1);
        for (int k = 0; k < NB; k++) cmetric[k*MW +: MW] = MW'(k + 10);
        cmetric[9*MW +: MW] = 16'h4000;
        best_label = 16'h0000;
        part_label = 16'h0200;
        cand_ped = 16'h4000;
        run("R1 disagree");
        chk("R1 disagree value", thresh, 16'h4000);
        part_label = 16'h0000;
        run("R1 agree");
        chk("R1 agree value", thresh, MW'(3 + 10));

        // R2: low levels always in, regardless of labels.
        child_lvl = LW'(2);
        part_label = 16'h00FF; best_label = 16'h00FF;
        cmetric[6*MW +: MW] = 16'h3000;
        run("R2 low in");
        chk("R2 low value", thresh, 16'h3000);

        // R4: equality kept, one above pruned.
        cand_ped = 16'h3000;
        run("R4 equal");
        chk("R4 equal kept", {{(MW-1){1'b0}}, prune}, '0);
        cand_ped = 16'h3001;
        run("R4 above");
        chk("R4 above pruned", {{(MW-1){1'b0}}, prune}, 16'h1);

        // R5: infinite metric in the set opens the threshold.
        cmetric[1*MW +: MW] = '1;
        cand_ped = '1;
        run("R5 inf in");
        chk("R5 inf thresh", thresh, '1);
        chk("R5 inf no prune", {{(MW-1){1'b0}}, prune}, '0);
        // Infinite metric on level 4 with agreeing labels stays out.
        cmetric[1*MW +: MW] = 16'h0001;
        cmetric[14*MW +: MW] = '1;
        part_label = 16'h0000; best_label = 16'h0000;
        run("R5 inf out");
        chk("R5 inf out thresh", thresh, 16'h3000);

        // R7: root children, labels ignored.
        for (int t = 0; t < 200; t++) begin
            logic [MW-1:0] ref_t;
            rand_query(NLVL);
            pick_ped();
            run("R7 root");
            ref_t = exp_thr(NLVL, '0, '0, cmetric);
            chk("R7 root all", thresh, ref_t);
        end

        // R6: flipping low-level label bits changes nothing.
        for (int t = 0; t < 300; t++) begin
            logic [MW-1:0] t0;
            logic p0;
            logic [NB-1:0] lowm;
            int lvl = 1 + int'($urandom % NLVL);
            rand_query(lvl);
            pick_ped();
            run("R6 base");
            t0 = thresh; p0 = prune;
            lowm = (NB'(1) << (lvl * NBIT)) - NB'(1);
            part_label = part_label ^ (NB'($urandom) & lowm);
            best_label = best_label ^ (NB'($urandom) & lowm);
            run("R6 flip");
            chk("R6 thresh same", thresh, t0);
            chk("R6 prune same", {{(MW-1){1'b0}}, prune}, {{(MW-1){1'b0}}, p0});
        end

        // R1 R2 R3 R4: mixed random queries.
        for (int t = 0; t < 2000; t++) begin
            rand_query(1 + int'($urandom % NLVL));
            pick_ped();
            run("R3 random");
        end

        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL R8 watchdog expired actual=hung expected=done");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end
endmodule